// File: doc/BRIEF.md
# Program Counter and Control-Transfer Unit

This block owns the fetch address of a 32-bit load/store processor core. Every clock it decodes the instruction word it is given, together with the two operand register values read for that instruction, and decides where the next fetch comes from. The choices are the following word, a conditional PC-relative branch, an absolute jump inside the current 256 MB region, a jump-and-link that also returns a link value, or a jump to an address held in a register.

Branches and jumps take effect on the very next PC with no delay slot. A hold input freezes the PC for pipeline stalls. An asynchronous reset loads a start address set by a parameter. The next-PC value is also available as a combinational output so that an instruction memory can be addressed one cycle early.

Top module: `pc_steer`

## Requirements
- R1: While rst_n is low, pc equals the parameter START_PC (default 0x00400000).
- R2: An instruction whose opcode (bits 31:26) is not 0, 2, 3, 4 or 5 advances pc by 4 at the next rising edge. An opcode-0 instruction whose funct (bits 5:0) is not 8 also advances pc by 4.
- R3: Opcode 4 (branch-if-equal) with rs_val equal to rt_val sets pc to pc + 4 + (sign-extended bits 15:0 × 4). When the values differ, pc advances by 4.
- R4: Opcode 5 (branch-if-not-equal) with rs_val different from rt_val takes the same target as in R3. When the values are equal, pc advances by 4.
- R5: Opcode 2 (jump) sets pc to {pc[31:28], bits 25:0, 2'b00}, so the upper 4 PC bits never change.
- R6: Opcode 3 (jump-and-link) jumps as in R5. While it is presented and hold is low, link_we is 1, link_addr is 31 and link_data is pc + 4. For example, word 0x0C10000C at pc 0x00400000 jumps to 0x00400030.
- R7: Opcode 0 with funct 8 (register jump) sets pc to rs_val.
- R8: While hold is high, pc keeps its value, next_pc equals pc, and link_we is 0 even for a jump-and-link instruction.
- R9: link_we is 0 for every instruction other than opcode 3.
- R10: next_pc always equals the value pc takes at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| hold | input | 1 | Stall: keep PC |
| instr | input | 32 | Current instruction word |
| rs_val | input | 32 | First operand register value |
| rt_val | input | 32 | Second operand register value |
| pc | output | 32 | Current program counter |
| next_pc | output | 32 | Address the PC loads at the next edge |
| link_we | output | 1 | Link register write request |
| link_addr | output | 5 | Link register index (31) |
| link_data | output | 32 | Return address written on link |

## Verification
Conditional branches are swept over a set of offsets that includes zero, ±1 and both extremes of the 16-bit field. Each offset is tried from several starting PCs, with equal and unequal operands for both branch kinds. This separates a wrong sign extension, a missing ×4 scale, an add to pc instead of pc+4, and swapped taken/not-taken conditions. Jumps are run from all sixteen upper-nibble regions with walking target bits, which exposes a region taken from the wrong place or a misplaced target field. All 64 opcodes and all 64 funct codes of opcode 0 are walked to show that only the listed encodings redirect the PC or request a link write, and stalls are applied on a jump-and-link to show that the write request is suppressed.

// File: rtl/pc_steer.sv
module pc_steer #(
  parameter logic [31:0] START_PC = 32'h0040_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hold,
  input  logic [31:0] instr,
  input  logic [31:0] rs_val,
  input  logic [31:0] rt_val,
  output logic [31:0] pc,
  output logic [31:0] next_pc,
  output logic        link_we,
  output logic [4:0]  link_addr,
  output logic [31:0] link_data
);
  localparam logic [5:0] OP_SPECIAL = 6'd0;
  localparam logic [5:0] OP_JUMP    = 6'd2;
  localparam logic [5:0] OP_JLINK   = 6'd3;
  localparam logic [5:0] OP_BREQ    = 6'd4;
  localparam logic [5:0] OP_BRNE    = 6'd5;
  localparam logic [5:0] FN_JREG    = 6'd8;
  localparam logic [4:0] LINK_REG   = 5'd31;

  logic [5:0]  opcode, funct;
  logic [31:0] seq_pc, br_pc, jmp_pc, flow_pc;
  logic        same;

  assign opcode = instr[31:26];
  assign funct  = instr[5:0];
  assign same   = (rs_val == rt_val);
  assign seq_pc = pc + 32'd4;
  assign br_pc  = seq_pc + {{14{instr[15]}}, instr[15:0], 2'b00};
  assign jmp_pc = {pc[31:28], instr[25:0], 2'b00};

  always_comb begin
    flow_pc = seq_pc;
    unique case (opcode)
      OP_SPECIAL: if (funct == FN_JREG) flow_pc = rs_val;
      OP_JUMP,
      OP_JLINK:   flow_pc = jmp_pc;
      OP_BREQ:    if (same)  flow_pc = br_pc;
      OP_BRNE:    if (!same) flow_pc = br_pc;
      default:    flow_pc = seq_pc;
    endcase
  end

  assign next_pc   = hold ? pc : flow_pc;
  assign link_we   = !hold && (opcode == OP_JLINK);
  assign link_addr = LINK_REG;
  assign link_data = seq_pc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= START_PC;
    else        pc <= next_pc;
  end
endmodule

// File: rtl/pc_steer_chk.sv
module pc_steer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        hold,
  input logic [31:0] instr,
  input logic [31:0] rs_val,
  input logic [31:0] rt_val,
  input logic [31:0] pc,
  input logic [31:0] next_pc,
  input logic        link_we,
  input logic [4:0]  link_addr,
  input logic [31:0] link_data
);
  logic plain;
  assign plain = !(instr[31:26] inside {6'd0, 6'd2, 6'd3, 6'd4, 6'd5});

  AST_HOLD_KEEPS_PC: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(pc)); // R8
  AST_PLAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && plain) |=> pc == $past(pc) + 32'd4); // R2
  AST_REG_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && instr[31:26] == 6'd0 && instr[5:0] == 6'd8) |=> pc == $past(rs_val)); // R7
  AST_BEQ_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && instr[31:26] == 6'd4 && rs_val != rt_val) |=> pc == $past(pc) + 32'd4); // R3
  AST_BNE_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && instr[31:26] == 6'd5 && rs_val == rt_val) |=> pc == $past(pc) + 32'd4); // R4
  AST_JUMP_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && instr[31:27] == 5'b00001) |=> pc[31:28] == $past(pc[31:28])); // R5
  AST_LINK_ONLY_JAL: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> (instr[31:26] == 6'd3 && !hold && link_addr == 5'd31)); // R9
  AST_LINK_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |=> $past(link_data) == $past(pc) + 32'd4); // R6
  AST_NEXT_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> pc == $past(next_pc)); // R10
endmodule

bind pc_steer pc_steer_chk u_chk (.*);

// File: tb/pc_steer_test.sv
module pc_steer_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        hold = 0;
  logic [31:0] instr = 32'h0;
  logic [31:0] rs_val = 32'h0;
  logic [31:0] rt_val = 32'h0;
  logic [31:0] pc, next_pc, link_data;
  logic        link_we;
  logic [4:0]  link_addr;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pc_steer uut (.clk(clk), .rst_n(rst_n), .hold(hold), .instr(instr),
    .rs_val(rs_val), .rt_val(rt_val), .pc(pc), .next_pc(next_pc),
    .link_we(link_we), .link_addr(link_addr), .link_data(link_data));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one instruction, check combinational outputs, then the new pc
  task automatic run(string tag, logic [31:0] w, logic [31:0] a, logic [31:0] b,
                     logic h, logic [31:0] exp_pc, logic exp_we);
    logic [31:0] start;
    @(negedge clk);
    instr = w; rs_val = a; rt_val = b; hold = h;
    start = pc;
    #2;
    chk({tag, " next_pc R10"}, next_pc, exp_pc);
    chk({tag, " link_we R9"}, {31'd0, link_we}, {31'd0, exp_we});
    if (exp_we) begin
      chk({tag, " link_addr R6"}, {27'd0, link_addr}, 32'd31);
      chk({tag, " link_data R6"}, link_data, start + 32'd4);
    end
    @(posedge clk); #2;
    chk(tag, pc, exp_pc);
    hold = 0;
  endtask

  function automatic logic [31:0] jr_word();
    return {6'd0, 5'd2, 15'd0, 6'd8};
  endfunction

  task automatic set_pc(logic [31:0] v);
    run("R7 load", jr_word(), v, 32'd0, 1'b0, v, 1'b0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] p;
    logic [15:0] offs [8];
    logic [31:0] bases [4];
    offs  = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h000A, 16'hFFF6, 16'h1234};
    bases = '{32'h0040_0000, 32'h0000_0000, 32'h7FFF_FFF0, 32'hFFFF_0000};

    #35;
    chk("R1 reset pc", pc, 32'h0040_0000);
    @(negedge clk); rst_n = 1;
    #2 chk("R1 after release", pc, 32'h0040_0000);

    // R6 known encoding
    run("R6 jal example", 32'h0C10000C, 0, 0, 1'b0, 32'h0040_0030, 1'b1);

    // R2 every opcode outside the control set
    for (int op = 0; op < 64; op++) begin
      if (op inside {0, 2, 3, 4, 5}) continue;
      p = pc;
      run("R2 plain opcode", {op[5:0], 26'h2AB_CDEF}, 32'h5, 32'h5, 1'b0, p + 32'd4, 1'b0);
    end
    // R2 opcode 0 with every funct except 8
    for (int fn = 0; fn < 64; fn++) begin
      if (fn == 8) continue;
      p = pc;
      run("R2 special funct", {6'd0, 5'd2, 5'd3, 5'd4, 5'd0, fn[5:0]}, 32'h1000, 32'h0, 1'b0, p + 32'd4, 1'b0);
    end

    // R3 / R4 branch sweep
    foreach (bases[bi]) foreach (offs[oi]) for (int kind = 4; kind <= 5; kind++)
      for (int eq = 0; eq < 2; eq++) begin
        logic [31:0] tgt, b2;
        logic taken;
        int o;
        set_pc(bases[bi]);
        o = int'($signed(offs[oi]));
        tgt = bases[bi] + 32'd4 + 32'(o * 4);
        taken = (kind == 4) ? (eq == 1) : (eq == 0);
        b2 = eq ? 32'hCAFE_0001 : 32'hCAFE_0002;
        run(kind == 4 ? "R3 beq" : "R4 bne", {kind[5:0], 5'd1, 5'd2, offs[oi]},
            32'hCAFE_0001, b2, 1'b0, taken ? tgt : bases[bi] + 32'd4, 1'b0);
      end

    // R5 / R6 jumps from every region with walking target bits
    for (int r = 0; r < 16; r++) for (int bit_i = 0; bit_i < 26; bit_i += 5) begin
      logic [25:0] t;
      logic [31:0] base;
      t = 26'd1 << bit_i;
      base = {r[3:0], 28'h0FF_FFF0};
      set_pc(base);
      run("R5 j", {6'd2, t}, 0, 0, 1'b0, {r[3:0], t, 2'b00}, 1'b0);
      set_pc(base);
      run("R6 jal", {6'd3, ~t}, 0, 0, 1'b0, {r[3:0], ~t, 2'b00}, 1'b1);
    end

    // R7 register jump to several values
    for (int k = 0; k < 8; k++) begin
      logic [31:0] v;
      v = 32'h1357_9BDF * (k + 1);
      run("R7 jr", jr_word(), v, ~v, 1'b0, v, 1'b0);
    end

    // R8 hold on jal, branch and plain
    set_pc(32'h0040_1000);
    run("R8 hold jal", 32'h0C10000C, 0, 0, 1'b1, 32'h0040_1000, 1'b0);
    run("R8 hold beq", {6'd4, 5'd1, 5'd1, 16'h0010}, 7, 7, 1'b1, 32'h0040_1000, 1'b0);
    run("R8 hold jr", jr_word(), 32'h1234, 0, 1'b1, 32'h0040_1000, 1'b0);
    run("R8 released", {6'd8, 26'd0}, 0, 0, 1'b0, 32'h0040_1004, 1'b0);

    // R1 reset mid-run
    @(negedge clk); rst_n = 0;
    #2 chk("R1 async reset", pc, 32'h0040_0000);
    @(negedge clk); rst_n = 1;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule